// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between the address/data generation stage for stores and the data cache write port of an out-of-order core. A store is accepted once its base, offset and data are all known. The block adds base and offset to form the effective address and keeps the store in an age-ordered circular queue. Each entry holds the address, the data, a sequence tag, a valid flag and a committed flag. The commit logic marks entries committed one at a time, oldest first. Only committed entries drain to the cache, and they drain strictly from the head of the queue, each one waiting until the memory port is free. A flush, raised on an exception or a mispredict, discards every entry that is not yet committed. Committed entries survive a flush and still drain.

A load presents its address and its own sequence tag. The block compares that address with every buffered store. The answer is registered and returns one cycle later. If at least one store is both older than the load and at the same address, the data comes from the youngest such store (forward). If no store qualifies, the load is told to read the cache (bypass).

Top module: `store_fwd_buffer`

## Requirements
- R1: `st_ready` is low when the buffer holds DEPTH entries or `flush` is high. A store is accepted only in a cycle where `st_valid` and `st_ready` are both high.
- R2: The address written to memory is `st_base + st_offset`, taken modulo 2^AW.
- R3: `mem_wr_valid` is high only when the oldest buffered entry has been committed. An uncommitted store never reaches the memory port.
- R4: Entries are written to memory in the order they were accepted. While `mem_wr_valid` is high and `mem_port_free` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold steady. A write completes in a cycle where `mem_wr_valid` and `mem_port_free` are both high.
- R5: A `commit` pulse marks the oldest uncommitted entry as committed, at most one entry per cycle. A `commit` with no uncommitted entry has no effect.
- R6: `flush` discards every uncommitted entry at the next clock edge. Committed entries remain and still drain. A store offered in the same cycle as `flush` is not accepted.
- R7: `ld_resp_valid` is high in the cycle after `ld_valid`. `ld_fwd` low with `ld_resp_valid` high means the load must read the cache.
- R8: When one or more buffered stores are older than the load and at the same address, `ld_fwd` is 1 and `ld_data` is the data of the youngest of them. The match uses the buffer contents in the cycle the load is presented.
- R9: A store is older than a load when (load tag − store tag) mod 2^SEQ_W is nonzero and below 2^(SEQ_W−1). Stores that are not older than the load are ignored for forwarding.
- R10: When `commit` and `flush` arrive in the same cycle, the commit is applied first, and the entry it marks survives the flush.
- R11: After reset the buffer is empty: `st_ready` is 1, `mem_wr_valid` is 0 and `ld_resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store is offered |
| st_ready | output | 1 | The buffer can accept a store |
| st_base | input | AW | Base address of the store |
| st_offset | input | AW | Offset added to the base |
| st_data | input | DW | Store data |
| st_seq | input | SEQ_W | Sequence tag of the store |
| commit | input | 1 | Mark the oldest uncommitted entry committed |
| flush | input | 1 | Discard all uncommitted entries |
| mem_wr_valid | output | 1 | Head entry is committed and ready to write |
| mem_port_free | input | 1 | The cache write port accepts this cycle |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| ld_valid | input | 1 | A load is presented |
| ld_addr | input | AW | Load address |
| ld_seq | input | SEQ_W | Sequence tag of the load |
| ld_resp_valid | output | 1 | Load answer valid (one cycle after ld_valid) |
| ld_fwd | output | 1 | 1: take ld_data; 0: read the cache |
| ld_data | output | DW | Forwarded data |

## Verification
Stores are drawn from four effective addresses, so loads often match several entries at once. Several matches separate youngest-older selection from first-match or oldest-match selection. Load tags are spread a few positions on either side of the newest store tag, and tags wrap many times during the run, which exposes a wrong or non-modular age test. Directed sequences hold the memory port busy while commits, surplus commits, flushes, and commit-with-flush arrive. These show whether uncommitted entries leak to memory and whether committed entries are lost in a flush. The random phase mixes all inputs and runs long enough for every pointer to wrap.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  parameter int unsigned SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;

  // entry tag is older than load tag (modular distance in lower half)
  function automatic logic seq_older(input seq_t ent, input seq_t ld);
    seq_t diff;
    diff = ld - ent;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/sbuf_agen.sv
module sbuf_agen #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] eff_addr
);
  assign eff_addr = base + offset;
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd
  import sbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic [PW-1:0] head,
  input  logic          e_vld  [DEPTH],
  input  logic [AW-1:0] e_addr [DEPTH],
  input  seq_t          e_seq  [DEPTH],
  input  logic [AW-1:0] ld_addr,
  input  seq_t          ld_seq,
  output logic          hit,
  output logic [PW-1:0] sel
);
  // scan oldest to youngest; the last qualifying entry wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int idx;
      idx = int'(head) + i;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (e_vld[idx] && (e_addr[idx] == ld_addr) && seq_older(e_seq[idx], ld_seq)) begin
        hit = 1'b1;
        sel = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [AW-1:0]    st_base,
  input  logic [AW-1:0]    st_offset,
  input  logic [DW-1:0]    st_data,
  input  logic [SEQ_W-1:0] st_seq,
  input  logic             commit,
  input  logic             flush,
  output logic             mem_wr_valid,
  input  logic             mem_port_free,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [DW-1:0]    mem_wr_data,
  input  logic             ld_valid,
  input  logic [AW-1:0]    ld_addr,
  input  logic [SEQ_W-1:0] ld_seq,
  output logic             ld_resp_valid,
  output logic             ld_fwd,
  output logic [DW-1:0]    ld_data
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  seq_t          e_seq  [DEPTH];
  logic          e_vld  [DEPTH];
  logic          e_cmt  [DEPTH];

  logic [PW-1:0] head, tail, cptr;
  logic [CW-1:0] count, ncmt;
  logic [AW-1:0] st_ea;
  logic          fwd_hit;
  logic [PW-1:0] fwd_sel;
  logic          do_push, do_drain, do_cmt;

  sbuf_agen #(.AW(AW)) u_agen (
    .base(st_base), .offset(st_offset), .eff_addr(st_ea)
  );

  sbuf_fwd #(.DEPTH(DEPTH), .AW(AW)) u_fwd (
    .head(head), .e_vld(e_vld), .e_addr(e_addr), .e_seq(e_seq),
    .ld_addr(ld_addr), .ld_seq(ld_seq), .hit(fwd_hit), .sel(fwd_sel)
  );

  assign cptr         = ptr_add(head, int'(ncmt));
  assign st_ready     = (count < CW'(DEPTH)) && !flush;
  assign do_push      = st_valid && st_ready;
  assign mem_wr_valid = e_vld[head] && e_cmt[head];
  assign mem_wr_addr  = e_addr[head];
  assign mem_wr_data  = e_data[head];
  assign do_drain     = mem_wr_valid && mem_port_free;
  assign do_cmt       = commit && (ncmt < count);

  // payload storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (do_push) begin
      e_addr[tail] <= st_ea;
      e_data[tail] <= st_data;
      e_seq[tail]  <= st_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      ncmt  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_vld[i] <= 1'b0;
        e_cmt[i] <= 1'b0;
      end
    end else begin
      if (do_cmt) e_cmt[cptr] <= 1'b1;
      if (do_drain) begin
        e_vld[head] <= 1'b0;
        e_cmt[head] <= 1'b0;
        head        <= ptr_add(head, 1);
      end
      ncmt <= ncmt + CW'(do_cmt) - CW'(do_drain);
      if (flush) begin
        for (int i = 0; i < DEPTH; i++)
          if (!e_cmt[i] && !(do_cmt && (PW'(i) == cptr))) e_vld[i] <= 1'b0;
        tail  <= ptr_add(cptr, int'(do_cmt));
        count <= ncmt + CW'(do_cmt) - CW'(do_drain);
      end else begin
        if (do_push) begin
          e_vld[tail] <= 1'b1;
          e_cmt[tail] <= 1'b0;
          tail        <= ptr_add(tail, 1);
        end
        count <= count + CW'(do_push) - CW'(do_drain);
      end
    end
  end

  // registered load answer
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_resp_valid <= 1'b0;
      ld_fwd        <= 1'b0;
      ld_data       <= '0;
    end else begin
      ld_resp_valid <= ld_valid;
      ld_fwd        <= ld_valid && fwd_hit;
      ld_data       <= fwd_hit ? e_data[fwd_sel] : '0;
    end
  end

  a_r1_no_push_full: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |-> !st_ready);
  a_r3_write_committed: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (ncmt != '0));
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_port_free) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  a_r5_commit_bound: assert property (@(posedge clk) disable iff (rst)
    ncmt <= count);
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == ncmt));
  a_r7_resp_follows: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_resp_valid);
endmodule

// File: tb/store_fwd_buffer_tb.sv
`timescale 1ns/1ps
module store_fwd_buffer_tb;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic st_valid = 0, commit = 0, flush = 0, mem_port_free = 0, ld_valid = 0;
  logic [AW-1:0] st_base = 0, st_offset = 0, ld_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic [7:0] st_seq = 0, ld_seq = 0;
  logic st_ready, mem_wr_valid, ld_resp_valid, ld_fwd;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data, ld_data;

  always #2 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_base(st_base), .st_offset(st_offset), .st_data(st_data), .st_seq(st_seq),
    .commit(commit), .flush(flush), .mem_wr_valid(mem_wr_valid),
    .mem_port_free(mem_port_free), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_seq(ld_seq),
    .ld_resp_valid(ld_resp_valid), .ld_fwd(ld_fwd), .ld_data(ld_data)
  );

  typedef struct {logic [31:0] a; logic [31:0] d; logic [7:0] s; bit c;} ent_t;
  ent_t q[$];
  int total = 0, bad = 0, wr_cnt = 0;
  logic [7:0] nseq = 0;
  bit exp_rv = 0, exp_fwd = 0, done = 0;
  logic [31:0] exp_data = 0;

  function automatic bit older(logic [7:0] e, logic [7:0] l);
    logic [7:0] d;
    d = l - e;
    return (d != 0) && !d[7];
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // one cycle: inputs already driven after negedge
  task automatic cyc();
    bit er, ew, drain, pushed;
    #1;
    er = (q.size() < DEPTH) && !flush;
    chk("R1 st_ready", st_ready, er);
    ew = (q.size() > 0) && q[0].c;
    chk("R3 mem_wr_valid", mem_wr_valid, ew);
    if (ew) begin
      chk("R2 mem_wr_addr", mem_wr_addr, q[0].a);
      chk("R4 mem_wr_data", mem_wr_data, q[0].d);
    end
    chk("R7 ld_resp_valid", ld_resp_valid, exp_rv);
    if (exp_rv) chk("R8 ld_fwd", ld_fwd, exp_fwd);
    if (exp_rv && exp_fwd) chk("R8 ld_data", ld_data, exp_data);
    exp_rv = ld_valid;
    exp_fwd = 0;
    foreach (q[i])
      if (q[i].a == ld_addr && older(q[i].s, ld_seq)) begin
        exp_fwd = 1;
        exp_data = q[i].d;
      end
    exp_fwd = exp_fwd && ld_valid;
    drain = ew && mem_port_free;
    if (drain) wr_cnt++;
    if (commit)
      foreach (q[i])
        if (!q[i].c) begin q[i].c = 1; break; end
    if (drain) void'(q.pop_front());
    pushed = 0;
    if (flush) begin
      while (q.size() > 0 && !q[$].c) void'(q.pop_back());
    end else if (st_valid && er) begin
      q.push_back('{a: st_base + st_offset, d: st_data, s: st_seq, c: 0});
      pushed = 1;
    end
    if (pushed) nseq++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_store(logic [31:0] ea, logic [31:0] d);
    st_valid = 1;
    st_offset = 32'($urandom_range(0, 255));
    st_base = ea - st_offset;
    st_data = d;
    st_seq = nseq;
  endtask

  task automatic idle();
    st_valid = 0; commit = 0; flush = 0; ld_valid = 0;
  endtask

  task automatic clean();
    idle();
    flush = 1; cyc(); flush = 0;
    mem_port_free = 1;
    repeat (DEPTH + 2) cyc();
  endtask

  initial begin
    int w0;
    logic [7:0] s0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R11 st_ready", st_ready, 1);
    chk("R11 mem_wr_valid", mem_wr_valid, 0);
    chk("R11 ld_resp_valid", ld_resp_valid, 0);
    @(negedge clk);

    // R1: fill with port busy
    mem_port_free = 0;
    for (int i = 0; i < DEPTH; i++) begin set_store(32'h100 + 4*i, 32'hA000 + i); cyc(); end
    set_store(32'h200, 32'hBEEF);
    #1 chk("R1 full blocks", st_ready, 0);
    cyc();
    clean();

    // R5: surplus commits ignored
    mem_port_free = 0;
    w0 = wr_cnt;
    set_store(32'h40, 32'h11); cyc();
    set_store(32'h44, 32'h22); cyc();
    idle(); commit = 1; repeat (3) cyc();
    commit = 0; set_store(32'h48, 32'h33); cyc();
    idle(); mem_port_free = 1; repeat (5) cyc();
    chk("R5 writes", wr_cnt - w0, 2);
    chk("R5 uncommitted held", mem_wr_valid, 0);
    clean();

    // R6: flush keeps committed only
    mem_port_free = 0;
    w0 = wr_cnt;
    for (int i = 0; i < 3; i++) begin set_store(32'h80 + 4*i, 32'h50 + i); cyc(); end
    idle(); commit = 1; cyc(); commit = 0;
    flush = 1; set_store(32'h90, 32'h99); cyc(); idle();
    mem_port_free = 1; repeat (5) cyc();
    chk("R6 writes after flush", wr_cnt - w0, 1);

    // R10: commit and flush together
    mem_port_free = 0;
    w0 = wr_cnt;
    set_store(32'hC0, 32'h77); cyc();
    set_store(32'hC4, 32'h78); cyc();
    idle(); commit = 1; flush = 1; cyc(); idle();
    mem_port_free = 1; repeat (4) cyc();
    chk("R10 writes", wr_cnt - w0, 1);

    // R9 / R8: age filtering
    mem_port_free = 0;
    s0 = nseq;
    set_store(32'h300, 32'h1111); cyc();
    set_store(32'h300, 32'h2222); cyc();
    idle(); ld_valid = 1; ld_addr = 32'h300; ld_seq = s0; cyc(); ld_valid = 0;
    chk("R9 younger ignored", ld_fwd, 0);
    ld_valid = 1; ld_seq = s0 + 1; cyc(); ld_valid = 0;
    chk("R9 picks older only", ld_data, 32'h1111);
    ld_valid = 1; ld_seq = s0 + 5; cyc(); ld_valid = 0;
    chk("R8 youngest older", ld_data, 32'h2222);
    ld_valid = 1; ld_addr = 32'h304; cyc(); ld_valid = 0;
    chk("R7 bypass", ld_fwd, 0);
    clean();

    // random mix
    for (int n = 0; n < 6000; n++) begin
      idle();
      if ($urandom_range(0, 1) == 1)
        set_store(32'h40 * $urandom_range(1, 4), $urandom);
      commit = ($urandom_range(0, 9) < 4);
      flush = ($urandom_range(0, 99) < 3);
      mem_port_free = $urandom_range(0, 1);
      ld_valid = $urandom_range(0, 1);
      ld_addr = 32'h40 * $urandom_range(1, 4);
      ld_seq = nseq + 8'($urandom_range(0, 5)) - 8'd3;
      cyc();
    end
    idle();
    cyc();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule